// File: doc/BRIEF.md
# I2C to SPI Command Bridge

This block lets an I2C host send commands to a device that only has an SPI port. Toward the host it is an I2C target at a fixed 7-bit address. Toward the device it is an SPI master in mode 0 (clock idles low, data sampled on the rising edge, most significant bit first). The I2C address byte and every acknowledge slot stay on the I2C side. Only the command bytes reach the SPI wire, so the device sees an ordinary SPI command stream whose first byte is the host's opcode: 82h config write, 83h config read, 86h coefficient write or 87h coefficient read.

When its address matches and it has acknowledged, the bridge drops SPI select. In a write-direction transfer, each received byte is shifted out on MOSI before the bridge acknowledges it. In a read-direction transfer, the bridge runs one SPI byte for each byte the host requests. It sends 00h on MOSI and returns the MISO byte on SDA. While an SPI byte is in flight, the bridge holds SCL low. Select is released on STOP and on a repeated START, and a repeated START opens a new SPI transaction. A host NACK ends a read. SCL and SDA are open-drain: the block only ever pulls a line low, through an enable output.

Top module: `i2c_spi_cmd_bridge`

## Requirements
- R1: During and after reset, with the bus idle, SPI select is high, SCK is low, and neither SCL nor SDA is pulled low.
- R2: An address byte whose upper seven bits equal the DEV_ADDR parameter is acknowledged: SDA is low during the 9th SCL clock. SPI select is low from that acknowledge onward.
- R3: An address byte that does not match is not acknowledged. After it, the bridge acknowledges nothing, drives nothing and starts no SPI byte until the next START. The first matching address after that START is served normally.
- R4: In a write-direction transfer (address bit 0 = 0), each data byte after the address goes out on MOSI unchanged and in arrival order, with MSB first and the opcode as the first byte. The address byte never appears on SPI. MOSI only changes while SCK is low.
- R5: Each write data byte is acknowledged only after its SPI byte has completed. SCL is held low by the bridge for as long as an SPI byte is in flight.
- R6: In a read-direction transfer (address bit 0 = 1), each byte the host clocks in is the MISO byte of a fresh SPI byte. That SPI byte carries 00h on MOSI, and the bridge stretches SCL until the byte is ready.
- R7: After the host answers a read byte with NACK (SDA high in the 9th clock), no further SPI byte is started and SDA is released.
- R8: A STOP condition releases SPI select on the next clock.
- R9: A repeated START releases SPI select. A matching address after it asserts select again, so a new SPI transaction starts.
- R10: SCK stays low whenever SPI select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the I2C clock line |
| sda_i | input | 1 | Sensed level of the I2C data line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| spi_cs_n | output | 1 | SPI select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |

## Verification
Some rules are checked on every cycle by properties:
- whenever an SPI byte is busy, SCL is held;
- SCK is quiet while select is high;
- SDA only moves while the sensed SCL is low;
- MOSI holds through each SCK high phase;
- STOP and START each release select;
- the bridge stays silent after an address miss and after a host NACK.

Other behaviour only the bench's scenarios can show. These are: the exact byte order on MOSI, with the address stripped; that a write is acknowledged only after its SPI byte; the values returned on reads; and that select comes back once for each repeated START. They also show that a bridge which missed its address responds again after a later START.

// File: rtl/i2c_spi_bridge_pkg.sv
package i2c_spi_bridge_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_WR_BITS,
        ST_WR_END,
        ST_WR_XFER,
        ST_WR_ACK,
        ST_RD_XFER,
        ST_RD_BITS,
        ST_RD_ACK,
        ST_HOLD,
        ST_MISS
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_spi_bridge_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import i2c_spi_bridge_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx,
    output logic              sck,
    output logic              mosi
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int PH_W  = $clog2(2 * BYTE_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [DIV_W-1:0]  div;
    logic [PH_W-1:0]   ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            sck  <= 1'b0;
            sh   <= '0;
            rx   <= '0;
            div  <= '0;
            ph   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sh   <= tx;
                    div  <= '0;
                    ph   <= '0;
                end
            end else if (div == DIV_LAST) begin
                div <= '0;
                ph  <= ph + 1'b1;
                if (!ph[0]) begin
                    sck <= 1'b1;
                    rx  <= {rx[BYTE_W-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    sh  <= {sh[BYTE_W-2:0], 1'b0};
                    if (ph == PH_LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    assign mosi = sh[BYTE_W-1];

    // R4: data only moves while the clock is low
    a_r4_mosi_steady_sck_high: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R5: completion is reported once, as the byte ends
    a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_spi_bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              spi_done,
    input  logic [BYTE_W-1:0] spi_rx,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              cs_n,
    output logic              spi_start,
    output logic [BYTE_W-1:0] spi_tx,
    output tgt_state_e        state_o
);
    tgt_state_e        state;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              mack;

    assign state_o = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            cs_n      <= 1'b1;
            spi_start <= 1'b0;
            spi_tx    <= '0;
        end else begin
            spi_start <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                cs_n   <= 1'b1;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                cs_n   <= 1'b1;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR_BITS: if (ev.scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7)
                            state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
                    end
                    ST_ADDR_END: if (ev.scl_fall) begin
                        if (addr_hit(shreg, DEV_ADDR)) begin
                            sda_oe <= 1'b1;
                            cs_n   <= 1'b0;
                            rw     <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_MISS;
                        end
                    end
                    ST_ADDR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        if (rw) begin
                            scl_oe    <= 1'b1;
                            spi_start <= 1'b1;
                            spi_tx    <= '0;
                            state     <= ST_RD_XFER;
                        end else begin
                            state     <= ST_WR_BITS;
                        end
                    end
                    ST_WR_END: if (ev.scl_fall) begin
                        scl_oe    <= 1'b1;
                        spi_start <= 1'b1;
                        spi_tx    <= shreg;
                        state     <= ST_WR_XFER;
                    end
                    ST_WR_XFER: if (spi_done) begin
                        sda_oe <= 1'b1;
                        scl_oe <= 1'b0;
                        state  <= ST_WR_ACK;
                    end
                    ST_WR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WR_BITS;
                    end
                    ST_RD_XFER: if (spi_done) begin
                        shreg  <= spi_rx;
                        sda_oe <= ~spi_rx[BYTE_W-1];
                        scl_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RD_BITS;
                    end
                    ST_RD_BITS: if (ev.scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            sda_oe <= ~shreg[BYTE_W-2];
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            cnt    <= cnt + 3'd1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) mack <= ~ev.sda;
                        if (ev.scl_fall) begin
                            if (mack) begin
                                scl_oe    <= 1'b1;
                                spi_start <= 1'b1;
                                spi_tx    <= '0;
                                state     <= ST_RD_XFER;
                            end else begin
                                state     <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: SDA is only moved while the sensed clock is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(ev.scl));
endmodule

// File: rtl/i2c_spi_cmd_bridge.sv
module i2c_spi_cmd_bridge
    import i2c_spi_bridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
    parameter int                SCK_HALF    = 2,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso
);
    line_ev_t          ev;
    logic              spi_start, spi_busy, spi_done;
    logic [BYTE_W-1:0] spi_tx, spi_rx;
    tgt_state_e        state;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev),
        .spi_done(spi_done), .spi_rx(spi_rx),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cs_n(spi_cs_n),
        .spi_start(spi_start), .spi_tx(spi_tx), .state_o(state)
    );

    spi_byte_master #(.SCK_HALF(SCK_HALF)) u_spi (
        .clk(clk), .rst(rst), .start(spi_start), .tx(spi_tx),
        .miso(spi_miso), .busy(spi_busy), .done(spi_done), .rx(spi_rx),
        .sck(spi_sck), .mosi(spi_mosi)
    );

    // R5 / R6: an SPI byte in flight always has SCL held low
    a_r5_busy_holds_scl: assert property (@(posedge clk) disable iff (rst)
        spi_busy |-> scl_oe);

    // R10: no SPI clock while deselected
    a_r10_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R3: after an address miss the bridge stays silent
    a_r3_miss_is_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MISS) |-> (spi_cs_n && !sda_oe && !scl_oe && !spi_busy));

    // R7: after a host NACK nothing more is driven or transferred
    a_r7_nack_is_final: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (!sda_oe && !spi_busy));

    // R8: STOP releases select
    a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> spi_cs_n);

    // R9: a START releases select
    a_r9_start_releases: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> spi_cs_n);
endmodule

// File: tb/i2c_spi_cmd_bridge_tb_top.sv
module i2c_spi_cmd_bridge_tb_top;
    localparam logic [6:0] ADDR = 7'h2A;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe, spi_cs_n, spi_sck, spi_mosi, spi_miso;
    logic scl_bus, sda_bus;
    assign scl_bus = ~(m_scl_low | scl_oe);
    assign sda_bus = ~(m_sda_low | sda_oe);

    i2c_spi_cmd_bridge #(.DEV_ADDR(ADDR), .SCK_HALF(2), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int i);
        return 8'h5A ^ 8'(i * 37);
    endfunction

    // SPI device model and scoreboard monitor
    logic [7:0] s_in = '0, s_out = '0;
    int s_bits = 0, s_idx = 0, spi_bytes = 0, cs_releases = 0;
    int sck_desel = 0, stretch_cyc = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    assign spi_miso = s_out[7];

    initial forever begin
        @(negedge clk);
        if (!spi_cs_n && prev_cs) begin
            s_idx = 0; s_bits = 0; s_out = resp(0);
        end
        if (spi_cs_n && !prev_cs) cs_releases++;
        if (spi_sck && spi_cs_n) sck_desel++;
        if (scl_oe) stretch_cyc++;
        if (spi_sck && !prev_sck) begin
            s_in = {s_in[6:0], spi_mosi};
            s_bits++;
            if (s_bits == 8) begin
                s_bits = 0;
                spi_bytes++;
                if (exp_q.size() == 0)
                    check(1'b0, "R3 unexpected SPI byte", 32'(s_in), 32'h0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(s_in == e, "R4 SPI byte order/value", 32'(s_in), 32'(e));
                end
                s_idx++;
            end
        end
        if (!spi_sck && prev_sck) begin
            if (s_bits == 0) s_out = resp(s_idx);
            else             s_out = {s_out[6:0], 1'b0};
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    // I2C host driver
    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; waitq();
        m_scl_low = 1'b0; wait (scl_bus == 1'b1); waitq();
        m_sda_low = 1'b1; waitq();
        m_scl_low = 1'b1; waitq();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; waitq();
        m_scl_low = 1'b0; wait (scl_bus == 1'b1); waitq();
        m_sda_low = 1'b0; waitq();
    endtask

    task automatic clock_bit(input logic b, output logic r);
        m_sda_low = ~b; waitq();
        m_scl_low = 1'b0;
        wait (scl_bus == 1'b1);
        waitq();
        @(negedge clk);
        r = sda_bus;
        waitq();
        m_scl_low = 1'b1; waitq();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            d = {d[6:0], r};
        end
        clock_bit(~give_ack, r);
    endtask

    task automatic write_data(input logic [7:0] b);
        logic ack;
        int nb;
        nb = spi_bytes;
        exp_q.push_back(b);
        write_byte(b, ack);
        check(ack == 1'b1, "R5 data byte acknowledged", 32'(ack), 32'h1);
        check(spi_bytes == nb + 1, "R5 SPI byte done before ack", 32'(spi_bytes), 32'(nb + 1));
    endtask

    logic [7:0] cmd_a [4] = '{8'h82, 8'h10, 8'h55, 8'hAA};
    logic [7:0] cmd_b [5] = '{8'h86, 8'h01, 8'hF0, 8'h0F, 8'h3C};

    initial begin
        logic ack;
        logic [7:0] d;
        int nb, rel;
        repeat (5) @(negedge clk);
        check(spi_cs_n == 1'b1, "R1 cs_n in reset", 32'(spi_cs_n), 32'h1);
        check(spi_sck == 1'b0, "R1 sck in reset", 32'(spi_sck), 32'h0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released",
              32'({scl_oe, sda_oe}), 32'h0);
        check(spi_cs_n == 1'b1, "R1 cs_n after reset", 32'(spi_cs_n), 32'h1);

        // R2 R4 R5 R8: config write
        i2c_start();
        write_byte({ADDR, 1'b0}, ack);
        check(ack == 1'b1, "R2 address acknowledged", 32'(ack), 32'h1);
        check(spi_cs_n == 1'b0, "R2 select after match", 32'(spi_cs_n), 32'h0);
        for (int i = 0; i < 4; i++) write_data(cmd_a[i]);
        i2c_stop();
        repeat (10) @(negedge clk);
        check(spi_cs_n == 1'b1, "R8 select released by STOP", 32'(spi_cs_n), 32'h1);
        check(exp_q.size() == 0, "R4 all bytes forwarded", 32'(exp_q.size()), 32'h0);

        // R4: coefficient write
        i2c_start();
        write_byte({ADDR, 1'b0}, ack);
        check(ack == 1'b1, "R2 address acknowledged again", 32'(ack), 32'h1);
        for (int i = 0; i < 5; i++) write_data(cmd_b[i]);
        i2c_stop();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 coefficient bytes forwarded", 32'(exp_q.size()), 32'h0);

        // R6 R7 R9: config read with repeated START
        i2c_start();
        write_byte({ADDR, 1'b0}, ack);
        write_data(8'h83);
        write_data(8'h05);
        rel = cs_releases;
        i2c_start();
        write_byte({ADDR, 1'b1}, ack);
        check(ack == 1'b1, "R2 read address acknowledged", 32'(ack), 32'h1);
        check(cs_releases == rel + 1, "R9 select released by repeated START",
              32'(cs_releases), 32'(rel + 1));
        check(spi_cs_n == 1'b0, "R9 select asserted for new transaction", 32'(spi_cs_n), 32'h0);
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back(8'h00);
            read_byte(k < 2, d);
            check(d == resp(k), "R6 read byte", 32'(d), 32'(resp(k)));
        end
        nb = spi_bytes;
        repeat (200) @(negedge clk);
        check(spi_bytes == nb, "R7 no SPI byte after NACK", 32'(spi_bytes), 32'(nb));
        check(sda_oe == 1'b0, "R7 SDA released after NACK", 32'(sda_oe), 32'h0);
        i2c_stop();
        repeat (10) @(negedge clk);
        check(spi_cs_n == 1'b1, "R8 select released after read", 32'(spi_cs_n), 32'h1);

        // R3: address miss, then recovery on next START
        i2c_start();
        write_byte({ADDR ^ 7'h01, 1'b0}, ack);
        check(ack == 1'b0, "R3 miss not acknowledged", 32'(ack), 32'h0);
        check(spi_cs_n == 1'b1, "R3 select stays high", 32'(spi_cs_n), 32'h1);
        nb = spi_bytes;
        write_byte(8'h82, ack);
        check(ack == 1'b0, "R3 byte after miss ignored", 32'(ack), 32'h0);
        check(spi_bytes == nb, "R3 no SPI byte after miss", 32'(spi_bytes), 32'(nb));
        i2c_start();
        write_byte({ADDR, 1'b0}, ack);
        check(ack == 1'b1, "R3 served after next START", 32'(ack), 32'h1);
        write_data(8'h87);
        i2c_stop();
        repeat (20) @(negedge clk);

        check(stretch_cyc > 0, "R5 SCL stretched", 32'(stretch_cyc), 32'h1);
        check(sck_desel == 0, "R10 SCK low while deselected", 32'(sck_desel), 32'h0);
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 (bus held): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule